// File: doc/BRIEF.md
# Trigger-Driven Serial Event Builder

This block gathers the fragments that several front-end sources deliver for one trigger and merges them into a single output event. Each trigger brings a 16-bit trigger number. The builder opens the output event with a header that carries that number. It then empties the sources one at a time in ascending index order. From each source it forwards the data words until that source's closing word. It ends the event with a trailer that carries the trigger number again.

Every source prefixes its fragment with its own event number. The builder compares that number with the trigger number and restores alignment on its own. A source that lags behind has its stale fragments thrown away. A source that runs ahead is skipped with a marker word, and its fragment stays queued for a later trigger. A watchdog with a limit set at a port stops the builder from hanging on a source that has gone quiet. Triggers that arrive during a build wait in an 8-entry queue.

Top module: `event_builder`

## Requirements
- R1: For each accepted trigger the first output word has tag 01 and carries the trigger number in data bits 15:0, with all other data bits zero.
- R2: After the header, sources are visited in index order 0 to NSRC-1. Tag-00 words of a visited source are forwarded unchanged with tag 00 until that source's tag-10 word. Source tag-01, tag-10 and tag-11 words are never forwarded, and any word a source presents before its tag-01 word is consumed and dropped.
- R3: After the last source is finished, one word with tag 10 and the trigger number in bits 15:0 closes the event.
- R4: Source words use a 2-bit tag: 00 payload, 01 fragment start (event number in data bits 15:0), 10 fragment end, 11 filler, which is consumed and never forwarded.
- R5: A fragment start whose number is below the trigger number makes the builder drop that source's words up to and including the next tag-10 word, and then search again. This increments the mismatch count and sets the sticky error flag.
- R6: A fragment start whose number is above the trigger number is left unread. The builder emits a marker word with tag 11, kind 1 in data bits 19:16 and the source index in data bits 7:0. It then moves on, and the mismatch count increments.
- R7: A high `clr` for one cycle zeroes the mismatch count, the error flag and the overflow flag. Clear takes priority over any setting event in the same cycle.
- R8: Pending triggers are held in an 8-deep queue. A trigger presented while the queue is full is dropped and sets a sticky overflow flag.
- R9: When the current source presents no word for more than `timeout_limit` consecutive cycles, the builder emits a marker word with tag 11, kind 2 in bits 19:16 and the source index in bits 7:0. It then moves to the next source.
- R10: The output follows valid/ready. While `out_valid` is high and `out_ready` is low, the output word holds steady. No source word is consumed unless its forwarded copy fits, so no word is lost or duplicated.
- R11: After reset `out_valid`, every `src_ready` bit, the mismatch count, the error flag and the overflow flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger strobe |
| trig_num | input | 16 | Trigger number |
| src_valid | input | NSRC | Per-source word valid |
| src_tag | input | 2*NSRC | Per-source word tags, source i in bits 2i+1:2i |
| src_data | input | DW*NSRC | Per-source word data, source i in slice i |
| src_ready | output | NSRC | Per-source word accept |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output sink ready |
| out_tag | output | 2 | Output word tag |
| out_data | output | DW | Output word data |
| timeout_limit | input | 16 | Watchdog limit in cycles |
| clr | input | 1 | Clears mismatch count, error flag and overflow flag |
| mismatch_cnt | output | 8 | Saturating count of realignment events |
| err_flag | output | 1 | Sticky realignment flag |
| trig_ovf | output | 1 | Sticky trigger-queue overflow flag |

## Verification
If the source index or the trigger register is corrupted, the fault shows at the ports within one event. Fragments then come out in the wrong order, a header or trailer carries the wrong number, or markers appear where payload was expected. The scoreboard catches each of these on the first word that differs. A fault in the realignment logic leaves a stale fragment in the stream, or eats the fragment of the next trigger. That shows up as unexpected or missing payload either in the current event or in the next one. A handshake fault duplicates or skips a word at the very cycle it happens, so the per-word comparison reports it at once.

// File: rtl/ebld_pkg.sv
package ebld_pkg;
  typedef enum logic [1:0] {
    TAG_DATA = 2'b00,
    TAG_SOE  = 2'b01,
    TAG_EOE  = 2'b10,
    TAG_AUX  = 2'b11
  } tag_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HEAD = 2'd1,
    S_SRC  = 2'd2,
    S_TAIL = 2'd3
  } bstate_e;

  typedef enum logic [1:0] {
    M_WAIT = 2'd0,
    M_FWD  = 2'd1,
    M_DROP = 2'd2
  } smode_e;

  localparam int MK_LSB     = 16;
  localparam logic [3:0] MK_AHEAD   = 4'd1;
  localparam logic [3:0] MK_TIMEOUT = 4'd2;
endpackage

// File: rtl/ebld_trig_fifo.sv
module ebld_trig_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      if (do_push != do_pop) cnt_q <= do_push ? cnt_q + CW'(1) : cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/ebld_src_sel.sv
module ebld_src_sel #(
  parameter int NSRC = 5,
  parameter int DW   = 32,
  parameter int SW   = 3
) (
  input  logic [SW-1:0]      sel,
  input  logic               pop,
  input  logic [NSRC-1:0]    src_valid,
  input  logic [2*NSRC-1:0]  src_tag,
  input  logic [DW*NSRC-1:0] src_data,
  output logic [NSRC-1:0]    src_ready,
  output logic               h_valid,
  output logic [1:0]         h_tag,
  output logic [DW-1:0]      h_data
);
  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i]       = (sel == SW'(i));
    assign src_ready[i] = hit[i] && pop && src_valid[i];
  end

  always_comb begin
    h_valid = 1'b0;
    h_tag   = '0;
    h_data  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (hit[i]) begin
        h_valid = src_valid[i];
        h_tag   = src_tag[2*i +: 2];
        h_data  = src_data[DW*i +: DW];
      end
    end
  end
endmodule

// File: rtl/ebld_watchdog.sv
module ebld_watchdog #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)                  cnt_d = '0;
    else if (tick && !(&cnt_q))   cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q >= limit);
endmodule

// File: rtl/event_builder.sv
module event_builder
  import ebld_pkg::*;
#(
  parameter int NSRC   = 5,
  parameter int DW     = 32,
  parameter int TNW    = 16,
  parameter int TDEPTH = 8,
  parameter int WDW    = 16,
  parameter int CNTW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_valid,
  input  logic [TNW-1:0]     trig_num,
  input  logic [NSRC-1:0]    src_valid,
  input  logic [2*NSRC-1:0]  src_tag,
  input  logic [DW*NSRC-1:0] src_data,
  output logic [NSRC-1:0]    src_ready,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_tag,
  output logic [DW-1:0]      out_data,
  input  logic [WDW-1:0]     timeout_limit,
  input  logic               clr,
  output logic [CNTW-1:0]    mismatch_cnt,
  output logic               err_flag,
  output logic               trig_ovf
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  bstate_e        st_q, st_d;
  smode_e         mode_q, mode_d;
  logic [SW-1:0]  sel_q, sel_d;
  logic [TNW-1:0] cur_q, cur_d;
  logic           ov_q, ov_d;
  logic [1:0]     ot_q, ot_d;
  logic [DW-1:0]  od_q, od_d;
  logic [CNTW-1:0] mc_q, mc_d;
  logic           err_q, err_d, ovf_q, ovf_d;

  logic           trig_full, fifo_empty, fifo_pop;
  logic [TNW-1:0] fifo_dout;
  logic           h_valid, pop, advance, emit, mism, load, wd_exp, wd_restart;
  logic [1:0]     h_tag;
  logic [DW-1:0]  h_data;
  logic [TNW-1:0] h_num;

  ebld_trig_fifo #(.W(TNW), .DEPTH(TDEPTH)) u_tfifo (
    .clk(clk), .rst_n(rst_i_n), .push(trig_valid), .din(trig_num),
    .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty), .full(trig_full)
  );

  ebld_src_sel #(.NSRC(NSRC), .DW(DW), .SW(SW)) u_sel (
    .sel(sel_q), .pop(pop), .src_valid(src_valid), .src_tag(src_tag),
    .src_data(src_data), .src_ready(src_ready),
    .h_valid(h_valid), .h_tag(h_tag), .h_data(h_data)
  );

  ebld_watchdog #(.W(WDW)) u_wd (
    .clk(clk), .rst_n(rst_i_n), .restart(wd_restart),
    .tick((st_q == S_SRC) && !h_valid), .limit(timeout_limit), .expired(wd_exp)
  );

  assign h_num      = h_data[TNW-1:0];
  assign load       = !ov_q || out_ready;
  assign wd_restart = (st_q != S_SRC) || pop || advance;

  // next-state: event sequencing
  always_comb begin
    st_d = st_q; mode_d = mode_q; sel_d = sel_q; cur_d = cur_q;
    fifo_pop = 1'b0; pop = 1'b0; advance = 1'b0; emit = 1'b0; mism = 1'b0;
    ot_d = TAG_DATA; od_d = '0;
    unique case (st_q)
      S_IDLE: if (!fifo_empty) begin
        fifo_pop = 1'b1; cur_d = fifo_dout; st_d = S_HEAD;
      end
      S_HEAD: if (load) begin
        emit = 1'b1; ot_d = TAG_SOE; od_d[TNW-1:0] = cur_q;
        sel_d = '0; mode_d = M_WAIT; st_d = S_SRC;
      end
      S_SRC: begin
        if (h_valid) begin
          unique case (mode_q)
            M_WAIT: begin
              if (h_tag != TAG_SOE) pop = 1'b1;
              else if (h_num == cur_q) begin pop = 1'b1; mode_d = M_FWD; end
              else if (h_num < cur_q) begin
                pop = 1'b1; mode_d = M_DROP; mism = 1'b1;
              end else if (load) begin
                emit = 1'b1; ot_d = TAG_AUX;
                od_d[MK_LSB +: 4] = MK_AHEAD; od_d[SW-1:0] = sel_q;
                mism = 1'b1; advance = 1'b1;
              end
            end
            M_FWD: begin
              if (h_tag == TAG_DATA) begin
                if (load) begin emit = 1'b1; ot_d = TAG_DATA; od_d = h_data; pop = 1'b1; end
              end else begin
                pop = 1'b1;
                if (h_tag == TAG_EOE) advance = 1'b1;
              end
            end
            default: begin
              pop = 1'b1;
              if (h_tag == TAG_EOE) mode_d = M_WAIT;
            end
          endcase
        end else if (wd_exp && load) begin
          emit = 1'b1; ot_d = TAG_AUX;
          od_d[MK_LSB +: 4] = MK_TIMEOUT; od_d[SW-1:0] = sel_q;
          advance = 1'b1;
        end
        if (advance) begin
          mode_d = M_WAIT;
          if (sel_q == SW'(NSRC - 1)) st_d = S_TAIL;
          else                        sel_d = sel_q + SW'(1);
        end
      end
      default: if (load) begin
        emit = 1'b1; ot_d = TAG_EOE; od_d[TNW-1:0] = cur_q; st_d = S_IDLE;
      end
    endcase
  end

  // next-state: output slot and status
  always_comb begin
    ov_d = ov_q;
    if (emit)           ov_d = 1'b1;
    else if (out_ready) ov_d = 1'b0;
    mc_d = mc_q; err_d = err_q; ovf_d = ovf_q;
    if (clr) begin
      mc_d = '0; err_d = 1'b0; ovf_d = 1'b0;
    end else begin
      if (mism) begin
        err_d = 1'b1;
        if (!(&mc_q)) mc_d = mc_q + CNTW'(1);
      end
      if (trig_valid && trig_full) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q <= S_IDLE; mode_q <= M_WAIT; sel_q <= '0; cur_q <= '0;
      ov_q <= 1'b0; ot_q <= '0; od_q <= '0;
      mc_q <= '0; err_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      st_q <= st_d; mode_q <= mode_d; sel_q <= sel_d; cur_q <= cur_d;
      ov_q <= ov_d; mc_q <= mc_d; err_q <= err_d; ovf_q <= ovf_d;
      if (emit) begin
        ot_q <= ot_d; od_q <= od_d;
      end
    end
  end

  assign out_valid    = ov_q;
  assign out_tag      = ot_q;
  assign out_data     = od_q;
  assign mismatch_cnt = mc_q;
  assign err_flag     = err_q;
  assign trig_ovf     = ovf_q;
endmodule

// File: rtl/event_builder_chk.sv
module event_builder_chk #(
  parameter int NSRC = 5,
  parameter int DW   = 32,
  parameter int CNTW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trig_valid,
  input logic            trig_full,
  input logic            clr,
  input logic [NSRC-1:0] src_valid,
  input logic [NSRC-1:0] src_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [1:0]      out_tag,
  input logic [DW-1:0]   out_data,
  input logic [CNTW-1:0] mismatch_cnt,
  input logic            err_flag,
  input logic            trig_ovf
);
  p_src_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ready));

  p_ready_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready & ~src_valid) == '0);

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_data)));

  p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && trig_full && !clr) |=> trig_ovf);

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> err_flag);

  p_cnt_implies_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch_cnt != '0) |-> err_flag);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mismatch_cnt == '0 && !err_flag && !trig_ovf));
endmodule

bind event_builder event_builder_chk #(.NSRC(NSRC), .DW(DW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_full(trig_full),
  .clr(clr), .src_valid(src_valid), .src_ready(src_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
  .out_data(out_data), .mismatch_cnt(mismatch_cnt), .err_flag(err_flag),
  .trig_ovf(trig_ovf)
);

// File: tb/event_builder_tb.sv
module event_builder_tb;
  localparam int NSRC = 5;
  localparam int DW   = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              trig_valid;
  logic [15:0]       trig_num;
  logic [NSRC-1:0]   src_valid;
  logic [2*NSRC-1:0] src_tag;
  logic [DW*NSRC-1:0] src_data;
  logic [NSRC-1:0]   src_ready;
  logic              out_valid, out_ready;
  logic [1:0]        out_tag;
  logic [DW-1:0]     out_data;
  logic [15:0]       timeout_limit;
  logic              clr;
  logic [7:0]        mismatch_cnt;
  logic              err_flag, trig_ovf;

  always #4 clk = ~clk;

  event_builder u_dut (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_num(trig_num),
    .src_valid(src_valid), .src_tag(src_tag), .src_data(src_data),
    .src_ready(src_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_tag(out_tag), .out_data(out_data), .timeout_limit(timeout_limit),
    .clr(clr), .mismatch_cnt(mismatch_cnt), .err_flag(err_flag), .trig_ovf(trig_ovf)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit hold_ready = 1'b0;
  bit run_drv = 1'b0;

  logic [33:0] sq [NSRC][$];
  logic [33:0] exp_q [$];
  string       exp_r [$];

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic load_frag(input int s, input int num, input int n);
    sq[s].push_back({2'b01, 16'h0, 16'(num)});
    for (int k = 0; k < n; k++) sq[s].push_back({2'b00, 32'((s << 24) | (num << 8) | k)});
    sq[s].push_back({2'b10, 32'h0});
  endtask

  task automatic exp_word(input logic [1:0] t, input logic [31:0] d, input string req);
    exp_q.push_back({t, d});
    exp_r.push_back(req);
  endtask

  task automatic exp_frag(input int s, input int num, input int n);
    for (int k = 0; k < n; k++) exp_word(2'b00, 32'((s << 24) | (num << 8) | k), "R2");
  endtask

  task automatic fire(input int num);
    @(negedge clk);
    trig_valid = 1'b1;
    trig_num   = 16'(num);
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // source and sink driver with scoreboard monitor
  initial begin
    src_valid = '0; src_tag = '0; src_data = '0; out_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (run_drv) begin
        for (int i = 0; i < NSRC; i++) begin
          if (sq[i].size() > 0 && ((cyc + i) % 3) != 0) begin
            src_valid[i] = 1'b1;
            src_tag[2*i +: 2]   = sq[i][0][33:32];
            src_data[DW*i +: DW] = sq[i][0][31:0];
          end else begin
            src_valid[i] = 1'b0;
          end
        end
        out_ready = !hold_ready && ((cyc % 4) != 1);
        #3;
        for (int i = 0; i < NSRC; i++)
          if (src_valid[i] && src_ready[i]) void'(sq[i].pop_front());
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected word", {out_tag, out_data}, 0);
          end else begin
            logic [33:0] e;
            string r;
            e = exp_q.pop_front();
            r = exp_r.pop_front();
            check({out_tag, out_data} === e, r, {out_tag, out_data}, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired with %0d words pending", exp_q.size());
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trig_valid = 1'b0; trig_num = '0; clr = 1'b0;
    timeout_limit = 16'd20;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
    check(src_ready == '0, "R11 src_ready", src_ready, 0);
    check(mismatch_cnt == 0 && !err_flag && !trig_ovf, "R11 status",
          {mismatch_cnt, err_flag, trig_ovf}, 0);
    run_drv = 1'b1;

    // event 1: clean, with filler (R4) and a stray word before start (R2)
    sq[0].push_back({2'b00, 32'hBAD0_0000});
    sq[2].push_back({2'b11, 32'hDEAD_BEEF});
    for (int s = 0; s < NSRC; s++) load_frag(s, 1, s + 1);
    exp_word(2'b01, 32'd1, "R1");
    for (int s = 0; s < NSRC; s++) exp_frag(s, 1, s + 1);
    exp_word(2'b10, 32'd1, "R3");
    fire(1);
    drain();

    // event 2: source 1 lags with a stale fragment (R5)
    load_frag(1, 1, 3);
    for (int s = 0; s < NSRC; s++) load_frag(s, 2, 2);
    exp_word(2'b01, 32'd2, "R1");
    for (int s = 0; s < NSRC; s++) exp_frag(s, 2, 2);
    exp_word(2'b10, 32'd2, "R3");
    fire(2);
    drain();
    check(mismatch_cnt == 1, "R5 mismatch count", mismatch_cnt, 1);
    check(err_flag == 1'b1, "R5 error flag", err_flag, 1);

    // event 3: source 3 runs ahead (R6); event 4 then uses its fragment
    for (int s = 0; s < NSRC; s++) load_frag(s, (s == 3) ? 4 : 3, 2);
    exp_word(2'b01, 32'd3, "R1");
    for (int s = 0; s < NSRC; s++) begin
      if (s == 3) exp_word(2'b11, 32'h0001_0003, "R6");
      else        exp_frag(s, 3, 2);
    end
    exp_word(2'b10, 32'd3, "R3");
    fire(3);
    drain();
    check(mismatch_cnt == 2, "R6 mismatch count", mismatch_cnt, 2);
    for (int s = 0; s < NSRC; s++) if (s != 3) load_frag(s, 4, 1);
    exp_word(2'b01, 32'd4, "R1");
    for (int s = 0; s < NSRC; s++) exp_frag(s, 4, (s == 3) ? 2 : 1);
    exp_word(2'b10, 32'd4, "R3");
    fire(4);
    drain();

    // event 5: source 4 silent (R9)
    for (int s = 0; s < 4; s++) load_frag(s, 5, 1);
    exp_word(2'b01, 32'd5, "R1");
    for (int s = 0; s < 4; s++) exp_frag(s, 5, 1);
    exp_word(2'b11, 32'h0002_0004, "R9");
    exp_word(2'b10, 32'd5, "R3");
    fire(5);
    drain();
    check(mismatch_cnt == 2, "R9 timeout is not a mismatch", mismatch_cnt, 2);

    // trigger queue overflow while the sink stalls (R8, R10)
    hold_ready = 1'b1;
    for (int t = 6; t <= 14; t++) begin
      exp_word(2'b01, 32'(t), "R8");
      for (int s = 0; s < NSRC; s++) exp_word(2'b11, 32'h0002_0000 | s, "R9");
      exp_word(2'b10, 32'(t), "R8");
    end
    fire(6);
    repeat (3) @(negedge clk);
    check(trig_ovf == 1'b0, "R8 no overflow yet", trig_ovf, 0);
    for (int t = 7; t <= 15; t++) begin
      @(negedge clk);
      trig_valid = 1'b1;
      trig_num   = 16'(t);
    end
    @(negedge clk);
    trig_valid = 1'b0;
    @(negedge clk);
    check(trig_ovf == 1'b1, "R8 overflow flag", trig_ovf, 1);
    check(out_valid == 1'b1, "R10 stalled word held", out_valid, 1);
    hold_ready = 1'b0;
    drain();
    repeat (60) @(negedge clk);
    check(exp_q.size() == 0, "R8 dropped trigger produced no event", exp_q.size(), 0);

    // clear (R7)
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(mismatch_cnt == 0 && !err_flag && !trig_ovf, "R7 clear",
          {mismatch_cnt, err_flag, trig_ovf}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule